// File: doc/BRIEF.md
# DDR burst data sequencer

This block moves the data beats of read and write bursts whose commands have already been decoded. A read command opens a burst at a column address. After the selected CAS latency, the block presents one data beat per clock together with a valid strobe. The beats walk through a block of columns aligned to the burst length and wrap inside it. A burst-terminate command ends a read early. Its effect appears on the data output after the same CAS latency. A new read can follow the current one directly, or cut it short, and the data stream keeps going with no gap.

A write command opens a window of single-rate data beats, one beat per clock, marked by a ready strobe. A mask bit that comes with each beat decides whether that beat reaches the storage array. A masked beat still uses its slot and its column, so the beats after it land where they would have landed anyway. The storage is a small synchronous memory inside the block. Strobe generation and double-edge I/O are left to the physical layer. Here every beat lasts one full clock.

Top module: `ddr_burst_seq`

## Requirements
- R1: While reset is held, and afterwards until a command arrives, `rd_valid` and `wr_ready` are low.
- R2: The first read beat is sampled `CL` clocks after the edge that registers `rd_cmd`. `cl_sel`=0 gives `CL`=2 and `cl_sel`=1 gives `CL`=3. So a read driven in cycle i shows its first beat, with `rd_valid` high, in cycle i+`CL`+1.
- R3: `bl_sel` picks the burst length for both reads and writes: 0 gives 2 beats, 1 gives 4, and 2 or 3 give 8. An uninterrupted read holds `rd_valid` high for exactly that many consecutive cycles.
- R4: Beat j of a burst at column c with length L uses column (c - c mod L) + ((c mod L + j) mod L).
- R5: A `bt_cmd` registered while a read is still issuing beats lets through only the beats issued before it. The output stops `CL` clocks after the terminate edge.
- R6: A `bt_cmd` registered while no read is issuing has no effect. It leaves write bursts and the output untouched.
- R7: A `rd_cmd` registered during a read burst starts the new burst on the next beat slot. The new beats follow the last old beat with no idle cycle, whether the old burst had finished or was cut short.
- R8: `wr_ready` goes high the cycle after `wr_cmd` is registered and stays high for the burst length. The `wr_data`/`wr_mask` pair driven in each ready cycle is taken at the following edge as the next beat.
- R9: A beat taken with `wr_mask`=1 leaves its column unchanged. The beats after it still go to their own columns as given by R4.
- R10: A `wr_cmd` registered during a write burst assigns the beat taken at that edge to the old burst. The new burst begins in the next cycle, and `wr_ready` does not drop.
- R11: A `rd_cmd` ends a write burst after the beat taken at the same edge, and `wr_ready` falls in the next cycle. A `wr_cmd` stops a read from issuing further beats in the same way a terminate does. When both commands arrive together, the read wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | Decoded read command |
| wr_cmd | input | 1 | Decoded write command |
| bt_cmd | input | 1 | Decoded burst-terminate command |
| col_addr | input | COL_W (6) | Starting column of the burst |
| bl_sel | input | 2 | Burst length code (R3) |
| cl_sel | input | 1 | CAS latency code, 0 selects 2 and 1 selects 3 |
| wr_data | input | DATA_W (8) | Write beat data |
| wr_mask | input | 1 | High to drop the current write beat |
| rd_data | output | DATA_W (8) | Read beat data |
| rd_valid | output | 1 | High for each read beat |
| wr_ready | output | 1 | High while write beats are expected |

## Verification
A wrong beat counter in the read path shows up at the ports as a `rd_valid` run that is too long or too short. It becomes visible exactly `CL` + burst-length cycles after the command. A wrong latency tag moves the whole run by a cycle, right from its first beat. A wrap or address-step fault first appears as wrong `rd_data` on the beat that crosses the aligned block boundary. A mask or write-address fault stays hidden until the same columns are read back, so every write scenario is followed by a readback burst over the columns it touched.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

  localparam int ADDR_MAX_W = 16;

  // beats in a burst for a length code
  function automatic logic [3:0] beats_of(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // low column bits that wrap inside the aligned block
  function automatic logic [2:0] wrap_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  // next column of a burst: upper bits frozen, lower bits count modulo length
  function automatic logic [ADDR_MAX_W-1:0] wrap_next(input logic [ADDR_MAX_W-1:0] col,
                                                      input logic [1:0] code);
    logic [ADDR_MAX_W-1:0] m;
    m = {{(ADDR_MAX_W-3){1'b0}}, wrap_mask(code)};
    return (col & ~m) | ((col + 1'b1) & m);
  endfunction

endpackage

// File: rtl/dbs_rd_issue.sv
module dbs_rd_issue
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 6,
  parameter int CLW   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic             wr_cmd,
  input  logic             bt_cmd,
  input  logic [COL_W-1:0] col_addr,
  input  logic [1:0]       bl_sel,
  input  logic [CLW-1:0]   cl_sel,
  output logic             beat_vld,
  output logic [COL_W-1:0] beat_addr,
  output logic [CLW-1:0]   beat_cl
);

  logic             act_q;
  logic [COL_W-1:0] addr_q;
  logic [2:0]       left_q;
  logic [1:0]       blc_q;
  logic [CLW-1:0]   cl_q;
  logic             cut_evt;

  // a terminate or a write ends issuing at this edge
  assign cut_evt = act_q && (bt_cmd || wr_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      blc_q  <= '0;
      cl_q   <= '0;
    end else if (rd_cmd) begin
      act_q  <= 1'b1;
      addr_q <= col_addr;
      left_q <= 3'(beats_of(bl_sel) - 4'd1);
      blc_q  <= bl_sel;
      cl_q   <= cl_sel;
    end else if (cut_evt) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      if (left_q == 3'd0) begin
        act_q <= 1'b0;
      end else begin
        addr_q <= COL_W'(wrap_next(ADDR_MAX_W'(addr_q), blc_q));
        left_q <= left_q - 3'd1;
      end
    end
  end

  assign beat_vld  = act_q;
  assign beat_addr = addr_q;
  assign beat_cl   = cl_q;

endmodule

// File: rtl/dbs_wr_accept.sv
module dbs_wr_accept
  import ddr_burst_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              rd_cmd,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [1:0]        bl_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mask,
  output logic              wr_ready,
  output logic              mem_we,
  output logic [COL_W-1:0]  mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic             act_q;
  logic [COL_W-1:0] addr_q;
  logic [2:0]       left_q;
  logic [1:0]       blc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      blc_q  <= '0;
    end else if (rd_cmd) begin
      act_q  <= 1'b0;
    end else if (wr_cmd) begin
      act_q  <= 1'b1;
      addr_q <= col_addr;
      left_q <= 3'(beats_of(bl_sel) - 4'd1);
      blc_q  <= bl_sel;
    end else if (act_q) begin
      if (left_q == 3'd0) begin
        act_q <= 1'b0;
      end else begin
        addr_q <= COL_W'(wrap_next(ADDR_MAX_W'(addr_q), blc_q));
        left_q <= left_q - 3'd1;
      end
    end
  end

  // the slot advances even when the mask suppresses the store
  assign wr_ready  = act_q;
  assign mem_we    = act_q && !wr_mask;
  assign mem_waddr = addr_q;
  assign mem_wdata = wr_data;

endmodule

// File: rtl/dbs_store.sv
module dbs_store #(
  parameter int COL_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [COL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dbs_rd_align.sv
module dbs_rd_align #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2,
  parameter int CLW    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic [CLW-1:0]    beat_cl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  // tags that travel beside the synchronous read
  logic           m_vld;
  logic [CLW-1:0] m_cl;

  logic [STAGES-1:0] st_vld;
  logic [CLW-1:0]    st_cl  [STAGES];
  logic [DATA_W-1:0] st_dat [STAGES];
  logic [STAGES-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_vld <= 1'b0;
      m_cl  <= '0;
    end else begin
      m_vld <= beat_vld;
      m_cl  <= beat_cl;
    end
  end

  // stage j is the exit for latency code j
  for (genvar j = 0; j < STAGES; j++) begin : g_stage
    if (j == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_vld[j] <= 1'b0;
          st_cl[j]  <= '0;
          st_dat[j] <= '0;
        end else begin
          st_vld[j] <= m_vld;
          st_cl[j]  <= m_cl;
          st_dat[j] <= mem_rdata;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_vld[j] <= 1'b0;
          st_cl[j]  <= '0;
          st_dat[j] <= '0;
        end else begin
          st_vld[j] <= st_vld[j-1];
          st_cl[j]  <= st_cl[j-1];
          st_dat[j] <= st_dat[j-1];
        end
      end
    end
    assign hit[j] = st_vld[j] && (st_cl[j] == CLW'(j));
  end

  always_comb begin
    out_vld  = |hit;
    out_data = '0;
    for (int j = STAGES - 1; j >= 0; j--) begin
      if (hit[j]) out_data = st_dat[j];
    end
  end

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_burst_pkg::*;
#(
  parameter int COL_W   = 6,
  parameter int DATA_W  = 8,
  parameter int CL_OPTS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_cmd,
  input  logic                   wr_cmd,
  input  logic                   bt_cmd,
  input  logic [COL_W-1:0]       col_addr,
  input  logic [1:0]             bl_sel,
  input  logic [((CL_OPTS > 1) ? $clog2(CL_OPTS) : 1)-1:0] cl_sel,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   wr_mask,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  output logic                   wr_ready
);

  localparam int CLW = (CL_OPTS > 1) ? $clog2(CL_OPTS) : 1;

  // named internal events, also seen by the checker
  logic              rd_beat_vld;
  logic [COL_W-1:0]  rd_beat_addr;
  logic [CLW-1:0]    rd_beat_cl;
  logic              st_we;
  logic [COL_W-1:0]  st_waddr;
  logic [DATA_W-1:0] st_wdata;
  logic [DATA_W-1:0] st_rdata;

  dbs_rd_issue #(.COL_W(COL_W), .CLW(CLW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_cmd    (rd_cmd),
    .wr_cmd    (wr_cmd),
    .bt_cmd    (bt_cmd),
    .col_addr  (col_addr),
    .bl_sel    (bl_sel),
    .cl_sel    (cl_sel),
    .beat_vld  (rd_beat_vld),
    .beat_addr (rd_beat_addr),
    .beat_cl   (rd_beat_cl)
  );

  dbs_wr_accept #(.COL_W(COL_W), .DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cmd    (wr_cmd),
    .rd_cmd    (rd_cmd),
    .col_addr  (col_addr),
    .bl_sel    (bl_sel),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .wr_ready  (wr_ready),
    .mem_we    (st_we),
    .mem_waddr (st_waddr),
    .mem_wdata (st_wdata)
  );

  dbs_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .re    (rd_beat_vld),
    .raddr (rd_beat_addr),
    .rdata (st_rdata)
  );

  dbs_rd_align #(.DATA_W(DATA_W), .STAGES(CL_OPTS), .CLW(CLW)) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_vld  (rd_beat_vld),
    .beat_cl   (rd_beat_cl),
    .mem_rdata (st_rdata),
    .out_vld   (rd_valid),
    .out_data  (rd_data)
  );

endmodule

// File: rtl/dbs_chk.sv
module dbs_chk #(
  parameter int CLW = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_cmd,
  input logic           wr_cmd,
  input logic           bt_cmd,
  input logic [CLW-1:0] cl_sel,
  input logic           rd_valid,
  input logic           wr_ready,
  input logic           beat_vld
);

  // R1: outputs idle on the first edge after reset release
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rd_valid && !wr_ready));

  // R2: first beat after two or three clocks
  p_cl2_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && cl_sel == CLW'(0)) |-> ##3 rd_valid);

  p_cl3_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && cl_sel == CLW'(1)) |-> ##4 rd_valid);

  // R5: terminate ends issuing at once
  p_bt_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_cmd && beat_vld && !rd_cmd) |=> !beat_vld);

  // R8: write window opens the next cycle
  p_wr_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !rd_cmd) |=> wr_ready);

  // R11: a read closes the write window, a write stops read issue
  p_rd_closes_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> !wr_ready);

  p_wr_stops_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !rd_cmd) |=> !beat_vld);

endmodule

bind ddr_burst_seq dbs_chk #(.CLW(CLW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_cmd   (rd_cmd),
  .wr_cmd   (wr_cmd),
  .bt_cmd   (bt_cmd),
  .cl_sel   (cl_sel),
  .rd_valid (rd_valid),
  .wr_ready (wr_ready),
  .beat_vld (rd_beat_vld)
);

// File: tb/tb_ddr_burst_seq.sv
module tb_ddr_burst_seq;

  localparam int DW = 8;
  localparam int CW = 6;
  localparam int SL = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_cmd = 1'b0, wr_cmd = 1'b0, bt_cmd = 1'b0;
  logic [CW-1:0] col_addr = '0;
  logic [1:0]    bl_sel = '0;
  logic [0:0]    cl_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_mask = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, wr_ready;

  always #5 clk = ~clk;

  ddr_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .bt_cmd(bt_cmd),
    .col_addr(col_addr), .bl_sel(bl_sel), .cl_sel(cl_sel), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_data(rd_data), .rd_valid(rd_valid), .wr_ready(wr_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  bit            s_rd [SL], s_wr [SL], s_bt [SL], s_cl [SL], s_wm [SL];
  logic [CW-1:0] s_col [SL];
  logic [1:0]    s_bl [SL];
  logic [DW-1:0] s_wd [SL];
  bit            l_v [SL], l_rdy [SL];
  logic [DW-1:0] l_d [SL];
  logic [DW-1:0] ref_mem [64];

  function automatic int bl_beats(input int code);
    return (code == 0) ? 2 : (code == 1) ? 4 : 8;
  endfunction

  function automatic int wrap_at(input int col, input int code, input int j);
    int bl = bl_beats(code);
    return col - (col % bl) + ((col % bl + j) % bl);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_script();
    for (int i = 0; i < SL; i++) begin
      s_rd[i] = 0; s_wr[i] = 0; s_bt[i] = 0; s_cl[i] = 0; s_wm[i] = 0;
      s_col[i] = '0; s_bl[i] = '0; s_wd[i] = '0;
    end
  endtask

  // cycle i: sample outputs at the falling edge, then drive stimulus i
  task automatic run_script(input int n);
    for (int i = 0; i < SL; i++) begin
      @(negedge clk);
      l_v[i]   = rd_valid;
      l_d[i]   = rd_data;
      l_rdy[i] = wr_ready;
      if (i < n) begin
        rd_cmd = s_rd[i]; wr_cmd = s_wr[i]; bt_cmd = s_bt[i];
        col_addr = s_col[i]; bl_sel = s_bl[i]; cl_sel = s_cl[i];
        wr_data = s_wd[i]; wr_mask = s_wm[i];
      end else begin
        rd_cmd = 0; wr_cmd = 0; bt_cmd = 0; wr_mask = 0; wr_data = '0;
      end
    end
  endtask

  task automatic put_rd(input int c, input int col, input int code, input int cl);
    s_rd[c] = 1; s_col[c] = CW'(col); s_bl[c] = 2'(code); s_cl[c] = cl[0];
  endtask

  task automatic put_wr(input int c, input int col, input int code);
    s_wr[c] = 1; s_col[c] = CW'(col); s_bl[c] = 2'(code);
  endtask

  // beat j of a write burst driven in cycle c, model updated when unmasked
  task automatic put_beat(input int c, input int col, input int code, input int j,
                          input int val, input bit m);
    s_wd[c] = DW'(val); s_wm[c] = m;
    if (!m) ref_mem[wrap_at(col, code, j)] = DW'(val);
  endtask

  task automatic expect_beats(input string req, input int first, input int col,
                              input int code, input int nb, input bit tail);
    for (int j = 0; j < nb; j++) begin
      chk(l_v[first+j] == 1'b1, req, "rd_valid on beat", int'(l_v[first+j]), 1);
      chk(l_d[first+j] === ref_mem[wrap_at(col, code, j)], req, "rd_data",
          int'(l_d[first+j]), int'(ref_mem[wrap_at(col, code, j)]));
    end
    if (tail) chk(l_v[first+nb] == 1'b0, req, "rd_valid after burst", int'(l_v[first+nb]), 0);
  endtask

  task automatic expect_ready(input string req, input int from, input int to);
    for (int i = from; i <= to; i++)
      chk(l_rdy[i] == 1'b1, req, "wr_ready in window", int'(l_rdy[i]), 1);
    chk(l_rdy[to+1] == 1'b0, req, "wr_ready after window", int'(l_rdy[to+1]), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R1", "rd_valid in reset", int'(rd_valid), 0);
    chk(wr_ready == 1'b0, "R1", "wr_ready in reset", int'(wr_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0 && wr_ready == 1'b0, "R1", "outputs after release",
        int'({rd_valid, wr_ready}), 0);
  endtask

  // R10 concatenated BL8 writes fill all 64 columns
  task automatic t_fill();
    clear_script();
    for (int b = 0; b < 8; b++) put_wr(b*8, b*8, 2);
    for (int k = 0; k < 64; k++) put_beat(1+k, (k/8)*8, 2, k%8, k*5+17, 0);
    run_script(65);
    chk(l_rdy[0] == 1'b0, "R8", "wr_ready before command", int'(l_rdy[0]), 0);
    expect_ready("R10", 1, 64);
  endtask

  task automatic t_read_basic();
    clear_script();
    put_rd(0, 5, 2, 0);
    put_rd(10, 14, 1, 1);
    put_rd(20, 9, 0, 0);
    put_rd(30, 33, 3, 0);
    run_script(31);
    chk(l_v[2] == 1'b0, "R2", "no beat before CL2", int'(l_v[2]), 0);
    expect_beats("R4", 3, 5, 2, 8, 1);
    chk(l_v[13] == 1'b0, "R2", "no beat before CL3", int'(l_v[13]), 0);
    expect_beats("R2", 14, 14, 1, 4, 1);
    expect_beats("R3", 23, 9, 0, 2, 1);
    expect_beats("R3", 33, 33, 3, 8, 1);
  endtask

  task automatic t_terminate();
    clear_script();
    put_rd(0, 16, 2, 1);
    s_bt[3] = 1;
    run_script(4);
    chk(l_v[3] == 1'b0, "R5", "no early beat", int'(l_v[3]), 0);
    expect_beats("R5", 4, 16, 2, 3, 1);
  endtask

  task automatic t_bt_idle();
    int cnt = 0;
    clear_script();
    s_bt[0] = 1;
    put_wr(2, 40, 1);
    for (int j = 0; j < 4; j++) put_beat(3+j, 40, 1, j, 'hC0+j, 0);
    s_bt[3] = 1; s_bt[5] = 1;
    run_script(7);
    expect_ready("R6", 3, 6);
    for (int i = 0; i < SL; i++) cnt += int'(l_v[i]);
    chk(cnt == 0, "R6", "read beats after idle terminate", cnt, 0);
  endtask

  task automatic t_mask();
    clear_script();
    put_wr(0, 24, 2);
    for (int j = 0; j < 8; j++)
      put_beat(1+j, 24, 2, j, 'hA0+j, (j == 1 || j == 2 || j == 6));
    put_rd(12, 24, 2, 0);
    put_rd(24, 40, 1, 1);
    run_script(25);
    expect_ready("R8", 1, 8);
    expect_beats("R9", 15, 24, 2, 8, 1);
    expect_beats("R6", 28, 40, 1, 4, 1);
  endtask

  task automatic t_rd_concat();
    clear_script();
    put_rd(0, 0, 1, 0);
    put_rd(4, 50, 1, 0);
    put_rd(20, 8, 2, 1);
    put_rd(22, 3, 0, 1);
    run_script(23);
    expect_beats("R7", 3, 0, 1, 4, 0);
    expect_beats("R7", 7, 50, 1, 4, 1);
    expect_beats("R7", 24, 8, 2, 2, 0);
    expect_beats("R7", 26, 3, 0, 2, 1);
  endtask

  task automatic t_wr_cut();
    clear_script();
    put_wr(0, 56, 2);
    for (int j = 0; j < 3; j++) put_beat(1+j, 56, 2, j, 'h50+j, 0);
    put_wr(3, 60, 1);
    for (int j = 0; j < 4; j++) put_beat(4+j, 60, 1, j, 'h60+j, 0);
    put_wr(10, 32, 2);
    for (int j = 0; j < 3; j++) put_beat(11+j, 32, 2, j, 'h70+j, 0);
    put_rd(13, 56, 2, 0);
    put_rd(30, 32, 2, 0);
    put_wr(32, 0, 0);
    put_beat(33, 0, 0, 0, 'h90, 0);
    put_beat(34, 0, 0, 1, 'h91, 0);
    put_rd(40, 20, 0, 0);
    s_wr[40] = 1;
    put_rd(50, 0, 0, 1);
    run_script(51);
    expect_ready("R10", 1, 7);
    expect_ready("R11", 11, 13);
    expect_beats("R10", 16, 56, 2, 8, 1);
    expect_beats("R11", 33, 32, 2, 2, 1);
    expect_ready("R3", 33, 34);
    chk(l_rdy[41] == 1'b0, "R11", "read wins over write", int'(l_rdy[41]), 0);
    expect_beats("R11", 43, 20, 0, 2, 1);
    expect_beats("R11", 54, 0, 0, 2, 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_read_basic();
    t_terminate();
    t_bt_idle();
    t_mask();
    t_rd_concat();
    t_wr_cut();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule